// File: doc/BRIEF.md
# Staged Filter Coefficient Loader

This block holds the coefficient sets of a polyphase resampling filter. There is one bank for the luma plane and one for the chroma plane. A host programs each bank over a plain write strobe bus. It first writes the staging words of one phase entry. It then writes that plane's trigger address, which copies every staged word into the store at the plane's current phase pointer and moves the pointer to the next entry. Sixteen stage-then-trigger rounds fill the whole bank. The parameter `N_STAGE` picks the variant: 5 staging words per entry for the horizontal filter, or 2 for the vertical filter.

The filter datapath fetches a committed entry through a phase-indexed read port. A request is a single-cycle pulse on `rd_valid_i` carrying a plane and a phase. The response appears on `rd_valid_o` and `rd_data_o` exactly one cycle later. The port has no back-pressure: every request is accepted, and the consumer must take the response in the cycle `rd_valid_o` is high. A control word sets the filter bypass pin and can return both phase pointers to zero.

Status pins report each plane's phase pointer, a "bank fully programmed" flag and a sticky warning. The warning is raised when a trigger arrives before every staging word has been rewritten.

Top module: `coef_loader`

## Requirements
- R1: After reset, both phase pointers read 0, both full flags and both warnings are 0, the bypass output is 0, `rd_valid_o` is 0, and every stored entry reads back as all zeros.
- R2: The address map is as follows. Luma staging word k is at address k and chroma staging word k is at address 8+k, for k from 0 to N_STAGE-1. The luma trigger is at address N_STAGE, the chroma trigger at 8+N_STAGE, and the control word at 16. A write to a staging address alone changes neither the stored entries nor the phase pointer.
- R3: A trigger write commits the plane's staged words into the entry selected by that plane's current phase pointer, with staging word k placed in bits [32k+31:32k] of the entry, and then increments that pointer by one.
- R4: A phase pointer at 15 wraps to 0 on the next trigger.
- R5: A plane's full flag goes high in the cycle after the 16th trigger counted from reset or from the last pointer clear. It then stays high until a pointer clear or a reset.
- R6: The two planes are independent. A staging or trigger write to one plane leaves the other plane's pointer, flags and entries unchanged.
- R7: A trigger issued when some staging word of that plane has not been written since the plane's previous trigger still commits the retained staging values, and it sets that plane's sticky warning. The warning clears only on a pointer clear or a reset.
- R8: A read request, sampled with `rd_plane_i` (0 = luma, 1 = chroma) and `rd_phase_i`, produces `rd_valid_o` high with that entry on `rd_data_o` exactly one cycle later, and `rd_valid_o` low otherwise. A read of the entry that a trigger is writing in the same cycle returns the previous contents.
- R9: A control write loads bit 0 into `bypass_o`. When bit 1 of the same write is 1, it also zeroes both phase pointers and clears both full flags and both warnings. Bit 1 is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register word address |
| wr_data_i | input | WORD_W | Register write data |
| rd_valid_i | input | 1 | Coefficient read request |
| rd_plane_i | input | 1 | Plane of the read, 0 luma, 1 chroma |
| rd_phase_i | input | PHASE_W | Phase entry to read |
| rd_valid_o | output | 1 | Read response valid, one cycle after request |
| rd_data_o | output | N_STAGE*WORD_W | Committed entry, word k in bits [32k+31:32k] |
| bypass_o | output | 1 | Filter bypass control |
| luma_phase_o | output | PHASE_W | Luma phase pointer |
| chroma_phase_o | output | PHASE_W | Chroma phase pointer |
| luma_full_o | output | 1 | Luma bank fully programmed |
| chroma_full_o | output | 1 | Chroma bank fully programmed |
| luma_warn_o | output | 1 | Luma stale-commit warning |
| chroma_warn_o | output | 1 | Chroma stale-commit warning |

## Verification
The properties assume the inputs are known, 0 or 1, in every cycle after reset. They also assume `N_STAGE` is at most 7, so that each trigger address lies inside its plane's eight-word window. They treat a trigger write and a control write as mutually exclusive, which always holds because the bus carries one write per cycle. The stimulus changes inputs only on the falling clock edge, keeps every strobe at 0 while reset is held, and uses the default horizontal variant with addresses taken from the map in R2.

// File: rtl/coef_loader_pkg.sv
package coef_loader_pkg;
  // Plane selector used on the read port and in per-plane generate blocks.
  typedef enum logic [0:0] {
    PLANE_LUMA   = 1'b0,
    PLANE_CHROMA = 1'b1
  } plane_e;

  localparam int NUM_PLANES   = 2;
  localparam int PLANE_STRIDE = 8;   // words per plane window
  localparam int CTRL_OFFSET  = 16;  // control word address

  // Field positions inside the control word.
  localparam int CTRL_BYPASS_BIT = 0;
  localparam int CTRL_CLEAR_BIT  = 1;
endpackage

// File: rtl/coef_phase_ram.sv
module coef_phase_ram #(
  parameter int DATA_W  = 160,
  parameter int PHASES  = 16,
  parameter int PHASE_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [PHASE_W-1:0] wr_idx,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               rd_en,
  input  logic [PHASE_W-1:0] rd_idx,
  output logic [DATA_W-1:0]  rd_data
);
  logic [DATA_W-1:0] mem [PHASES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < PHASES; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_idx] <= wr_data;
    end
  end

  // Registered read sees the contents from before a same-cycle write.
  always_ff @(posedge clk) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= mem[rd_idx];
  end
endmodule

// File: rtl/coef_plane.sv
module coef_plane #(
  parameter int N_STAGE = 5,
  parameter int WORD_W  = 32,
  parameter int PHASES  = 16,
  parameter int PHASE_W = 4,
  parameter int SEL_W   = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      stage_we,
  input  logic [SEL_W-1:0]          stage_sel,
  input  logic [WORD_W-1:0]         stage_data,
  input  logic                      trig,
  input  logic                      ptr_clear,
  input  logic                      rd_en,
  input  logic [PHASE_W-1:0]        rd_idx,
  output logic [PHASE_W-1:0]        phase,
  output logic                      full,
  output logic                      warn,
  output logic [N_STAGE*WORD_W-1:0] rd_data
);
  localparam int ENTRY_W = N_STAGE * WORD_W;
  localparam logic [PHASE_W-1:0] LAST_PHASE = PHASE_W'(PHASES - 1);

  logic [ENTRY_W-1:0] stage_q;
  logic [N_STAGE-1:0] fresh_q;

  // One staging word and one freshness bit per position.
  for (genvar k = 0; k < N_STAGE; k++) begin : g_word
    logic hit;
    assign hit = stage_we && (stage_sel == SEL_W'(k));

    always_ff @(posedge clk) begin
      if (!rst_n)   stage_q[k*WORD_W +: WORD_W] <= '0;
      else if (hit) stage_q[k*WORD_W +: WORD_W] <= stage_data;
    end

    always_ff @(posedge clk) begin
      if (!rst_n)    fresh_q[k] <= 1'b0;
      else if (trig) fresh_q[k] <= 1'b0;
      else if (hit)  fresh_q[k] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || ptr_clear) begin
      phase <= '0;
      full  <= 1'b0;
      warn  <= 1'b0;
    end else if (trig) begin
      phase <= (phase == LAST_PHASE) ? '0 : phase + 1'b1;
      if (phase == LAST_PHASE) full <= 1'b1;
      if (!(&fresh_q))         warn <= 1'b1;
    end
  end

  coef_phase_ram #(
    .DATA_W  (ENTRY_W),
    .PHASES  (PHASES),
    .PHASE_W (PHASE_W)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (trig),
    .wr_idx  (phase),
    .wr_data (stage_q),
    .rd_en   (rd_en),
    .rd_idx  (rd_idx),
    .rd_data (rd_data)
  );
endmodule

// File: rtl/coef_loader.sv
module coef_loader
  import coef_loader_pkg::*;
#(
  parameter int N_STAGE = 5,   // 5 horizontal, 2 vertical; at most 7
  parameter int WORD_W  = 32,
  parameter int PHASES  = 16,
  parameter int ADDR_W  = 5,
  localparam int PHASE_W = $clog2(PHASES),
  localparam int ENTRY_W = N_STAGE * WORD_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [WORD_W-1:0]  wr_data_i,
  input  logic               rd_valid_i,
  input  logic               rd_plane_i,
  input  logic [PHASE_W-1:0] rd_phase_i,
  output logic               rd_valid_o,
  output logic [ENTRY_W-1:0] rd_data_o,
  output logic               bypass_o,
  output logic [PHASE_W-1:0] luma_phase_o,
  output logic [PHASE_W-1:0] chroma_phase_o,
  output logic               luma_full_o,
  output logic               chroma_full_o,
  output logic               luma_warn_o,
  output logic               chroma_warn_o
);
  localparam int SEL_W  = (N_STAGE > 1) ? $clog2(N_STAGE) : 1;
  localparam int OFF_W  = $clog2(PLANE_STRIDE);
  localparam int WIN_W  = ADDR_W - OFF_W;

  logic [OFF_W-1:0]   offset;
  logic               ctrl_hit;
  logic               ptr_clear;
  logic               rd_plane_q;
  logic [PHASE_W-1:0] phase_v [NUM_PLANES];
  logic               full_v  [NUM_PLANES];
  logic               warn_v  [NUM_PLANES];
  logic [ENTRY_W-1:0] rdata_v [NUM_PLANES];

  assign offset    = wr_addr_i[OFF_W-1:0];
  assign ctrl_hit  = wr_en_i && (wr_addr_i == ADDR_W'(CTRL_OFFSET));
  assign ptr_clear = ctrl_hit && wr_data_i[CTRL_CLEAR_BIT];

  for (genvar p = 0; p < NUM_PLANES; p++) begin : g_plane
    logic win_hit;
    logic stage_we;
    logic trig;

    assign win_hit  = wr_en_i && (wr_addr_i[ADDR_W-1:OFF_W] == WIN_W'(p));
    assign stage_we = win_hit && (offset < OFF_W'(N_STAGE));
    assign trig     = win_hit && (offset == OFF_W'(N_STAGE));

    coef_plane #(
      .N_STAGE (N_STAGE),
      .WORD_W  (WORD_W),
      .PHASES  (PHASES),
      .PHASE_W (PHASE_W),
      .SEL_W   (SEL_W)
    ) u_plane (
      .clk        (clk),
      .rst_n      (rst_n),
      .stage_we   (stage_we),
      .stage_sel  (offset[SEL_W-1:0]),
      .stage_data (wr_data_i),
      .trig       (trig),
      .ptr_clear  (ptr_clear),
      .rd_en      (rd_valid_i && (rd_plane_i == 1'(p))),
      .rd_idx     (rd_phase_i),
      .phase      (phase_v[p]),
      .full       (full_v[p]),
      .warn       (warn_v[p]),
      .rd_data    (rdata_v[p])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        bypass_o <= 1'b0;
    else if (ctrl_hit) bypass_o <= wr_data_i[CTRL_BYPASS_BIT];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid_o <= 1'b0;
      rd_plane_q <= 1'b0;
    end else begin
      rd_valid_o <= rd_valid_i;
      if (rd_valid_i) rd_plane_q <= rd_plane_i;
    end
  end

  assign rd_data_o      = rdata_v[rd_plane_q];
  assign luma_phase_o   = phase_v[PLANE_LUMA];
  assign chroma_phase_o = phase_v[PLANE_CHROMA];
  assign luma_full_o    = full_v[PLANE_LUMA];
  assign chroma_full_o  = full_v[PLANE_CHROMA];
  assign luma_warn_o    = warn_v[PLANE_LUMA];
  assign chroma_warn_o  = warn_v[PLANE_CHROMA];
endmodule

// File: rtl/coef_loader_chk.sv
module coef_loader_chk #(
  parameter int N_STAGE = 5,
  parameter int WORD_W  = 32,
  parameter int PHASES  = 16,
  parameter int ADDR_W  = 5,
  parameter int PHASE_W = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en_i,
  input logic [ADDR_W-1:0]  wr_addr_i,
  input logic [WORD_W-1:0]  wr_data_i,
  input logic               rd_valid_i,
  input logic               rd_valid_o,
  input logic [PHASE_W-1:0] luma_phase_o,
  input logic [PHASE_W-1:0] chroma_phase_o,
  input logic               luma_full_o,
  input logic               chroma_full_o,
  input logic               luma_warn_o,
  input logic               chroma_warn_o
);
  localparam logic [PHASE_W-1:0] LAST = PHASE_W'(PHASES - 1);

  logic l_trig, c_trig, clr;
  assign l_trig = wr_en_i && (wr_addr_i == ADDR_W'(N_STAGE));
  assign c_trig = wr_en_i && (wr_addr_i == ADDR_W'(8 + N_STAGE));
  assign clr    = wr_en_i && (wr_addr_i == ADDR_W'(16)) && wr_data_i[1];

  // R3 / R4: trigger advances the pointer with wrap
  a_r3_luma_advance: assert property (@(posedge clk) disable iff (!rst_n)
    l_trig |=> luma_phase_o == (($past(luma_phase_o) == LAST) ? '0 : $past(luma_phase_o) + 1'b1));
  a_r4_chroma_advance: assert property (@(posedge clk) disable iff (!rst_n)
    c_trig |=> chroma_phase_o == (($past(chroma_phase_o) == LAST) ? '0 : $past(chroma_phase_o) + 1'b1));
  // R2: without trigger or clear the pointer holds
  a_r2_luma_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_trig && !clr) |=> $stable(luma_phase_o));
  // R6: a luma trigger leaves chroma state alone
  a_r6_planes_apart: assert property (@(posedge clk) disable iff (!rst_n)
    l_trig |=> ($stable(chroma_phase_o) && $stable(chroma_full_o) && $stable(chroma_warn_o)));
  // R5: full only rises after a trigger and is sticky
  a_r5_full_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(luma_full_o) |-> $past(l_trig));
  a_r5_full_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (luma_full_o && !clr) |=> luma_full_o);
  // R7: warning is sticky
  a_r7_warn_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (luma_warn_o && !clr) |=> luma_warn_o);
  // R8: response one cycle after request
  a_r8_rd_valid: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_i |=> rd_valid_o);
  a_r8_rd_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid_i |=> !rd_valid_o);
  // R9: pointer clear zeroes everything it owns
  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (luma_phase_o == '0 && chroma_phase_o == '0 && !luma_full_o &&
             !chroma_full_o && !luma_warn_o && !chroma_warn_o));
endmodule

bind coef_loader coef_loader_chk #(
  .N_STAGE (N_STAGE),
  .WORD_W  (WORD_W),
  .PHASES  (PHASES),
  .ADDR_W  (ADDR_W),
  .PHASE_W (PHASE_W)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .wr_en_i        (wr_en_i),
  .wr_addr_i      (wr_addr_i),
  .wr_data_i      (wr_data_i),
  .rd_valid_i     (rd_valid_i),
  .rd_valid_o     (rd_valid_o),
  .luma_phase_o   (luma_phase_o),
  .chroma_phase_o (chroma_phase_o),
  .luma_full_o    (luma_full_o),
  .chroma_full_o  (chroma_full_o),
  .luma_warn_o    (luma_warn_o),
  .chroma_warn_o  (chroma_warn_o)
);

// File: tb/tb_coef_loader.sv
module tb_coef_loader;
  localparam int NS = 5;
  localparam int EW = NS * 32;
  localparam int NV = 23;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en_i = 1'b0;
  logic [4:0]    wr_addr_i = '0;
  logic [31:0]   wr_data_i = '0;
  logic          rd_valid_i = 1'b0;
  logic          rd_plane_i = 1'b0;
  logic [3:0]    rd_phase_i = '0;
  logic          rd_valid_o;
  logic [EW-1:0] rd_data_o;
  logic          bypass_o;
  logic [3:0]    luma_phase_o, chroma_phase_o;
  logic          luma_full_o, chroma_full_o, luma_warn_o, chroma_warn_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  coef_loader dut (.*);

  // {read_check, addr, data}; read_check: addr[4] plane, addr[3:0] phase, data = expected word 0
  localparam logic [37:0] VEC [NV] = '{
    {1'b0, 5'd0,  32'h1100_0000}, {1'b0, 5'd1,  32'h1100_0001},
    {1'b0, 5'd2,  32'h1100_0002}, {1'b0, 5'd3,  32'h1100_0003},
    {1'b0, 5'd4,  32'h1100_0004}, {1'b0, 5'd5,  32'h0},
    {1'b0, 5'd8,  32'h2200_0000}, {1'b0, 5'd9,  32'h2200_0001},
    {1'b0, 5'd10, 32'h2200_0002}, {1'b0, 5'd11, 32'h2200_0003},
    {1'b0, 5'd12, 32'h2200_0004}, {1'b0, 5'd13, 32'h0},
    {1'b0, 5'd0,  32'h3300_0000}, {1'b0, 5'd1,  32'h3300_0001},
    {1'b0, 5'd2,  32'h3300_0002}, {1'b0, 5'd3,  32'h3300_0003},
    {1'b0, 5'd4,  32'h3300_0004}, {1'b0, 5'd5,  32'h0},
    {1'b1, 5'h00, 32'h1100_0000}, {1'b1, 5'h01, 32'h3300_0000},
    {1'b1, 5'h10, 32'h2200_0000}, {1'b1, 5'h11, 32'h0},
    {1'b1, 5'h02, 32'h0}
  };

  task automatic check(input string req, input logic [EW-1:0] act, input logic [EW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic pl, input logic [3:0] ph, output logic [EW-1:0] q);
    @(negedge clk);
    rd_valid_i = 1'b1; rd_plane_i = pl; rd_phase_i = ph;
    @(negedge clk);
    rd_valid_i = 1'b0;
    check("R8 response valid", EW'(rd_valid_o), EW'(1));
    q = rd_data_o;
  endtask

  function automatic logic [EW-1:0] entry(input logic [31:0] base, input logic [31:0] w0);
    logic [EW-1:0] e;
    for (int k = 0; k < NS; k++) e[k*32 +: 32] = base + 32'(k);
    e[31:0] = w0;
    return e;
  endfunction

  initial begin
    logic [EW-1:0] q;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 pointers", EW'({luma_phase_o, chroma_phase_o}), EW'(0));
    check("R1 flags", EW'({luma_full_o, chroma_full_o, luma_warn_o, chroma_warn_o, bypass_o, rd_valid_o}), EW'(0));
    rd(1'b0, 4'd5, q);
    check("R1 store cleared", q, '0);

    // Table walk: R2 map, R3 commit, R6 independence
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][37]) begin
        rd(VEC[i][36], VEC[i][35:32], q);
        check("R3 table entry word0", EW'(q[31:0]), EW'(VEC[i][31:0]));
      end else begin
        wr(VEC[i][36:32], VEC[i][31:0]);
      end
    end
    check("R3 luma pointer", EW'(luma_phase_o), EW'(2));
    check("R6 chroma pointer", EW'(chroma_phase_o), EW'(1));
    rd(1'b0, 4'd1, q);
    check("R3 word placement", q, entry(32'h3300_0000, 32'h3300_0000));
    @(negedge clk);
    check("R8 valid drops", EW'(rd_valid_o), EW'(0));

    // R2 staging alone has no effect
    wr(5'd0, 32'h4400_0000);
    check("R2 pointer unchanged", EW'(luma_phase_o), EW'(2));
    rd(1'b0, 4'd2, q);
    check("R2 store unchanged", q, '0);

    // R7 partial staging then trigger
    wr(5'd5, 32'h0);
    check("R7 luma warn", EW'(luma_warn_o), EW'(1));
    check("R6 chroma warn", EW'(chroma_warn_o), EW'(0));
    rd(1'b0, 4'd2, q);
    check("R7 stale words committed", q, entry(32'h3300_0000, 32'h4400_0000));

    // R9 bypass and pointer clear
    wr(5'd16, 32'h1);
    check("R9 bypass set", EW'(bypass_o), EW'(1));
    check("R9 bypass keeps pointer", EW'({luma_phase_o, luma_warn_o}), EW'({4'd3, 1'b1}));
    wr(5'd16, 32'h2);
    check("R9 clear", EW'({bypass_o, luma_phase_o, chroma_phase_o, luma_warn_o}), EW'(0));

    // R4 wrap and R5 full
    for (int i = 0; i < 15; i++) wr(5'd5, 32'h0);
    check("R5 not full at 15", EW'({luma_phase_o, luma_full_o}), EW'({4'd15, 1'b0}));
    wr(5'd5, 32'h0);
    check("R4 wrap to 0", EW'(luma_phase_o), EW'(0));
    check("R5 full after 16", EW'({luma_full_o, chroma_full_o}), EW'(2'b10));
    check("R7 stale warn again", EW'(luma_warn_o), EW'(1));

    // R8 read of the entry being committed in the same cycle
    wr(5'd0, 32'h5500_0000);
    @(negedge clk);
    wr_en_i = 1'b1; wr_addr_i = 5'd5; wr_data_i = '0;
    rd_valid_i = 1'b1; rd_plane_i = 1'b0; rd_phase_i = 4'd0;
    @(negedge clk);
    wr_en_i = 1'b0; rd_valid_i = 1'b0;
    check("R8 old contents on collision", EW'(rd_data_o[31:0]), EW'(32'h4400_0000));
    rd(1'b0, 4'd0, q);
    check("R8 new contents after", EW'(q[31:0]), EW'(32'h5500_0000));
    check("R5 full sticky", EW'(luma_full_o), EW'(1));
    wr(5'd16, 32'h2);
    check("R5 full cleared", EW'(luma_full_o), EW'(0));

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule